// File: doc/BRIEF.md
# Ring Product-Term Allocation Network

This block sits between a product-term array and the output logic of a set of macrocells. Each cell brings in eight product terms, split into a lower group of four (group A) and an upper group of four (group B). A configuration word per cell says whether each group stays at home or goes to the cell just before it or just after it in the ring. The block ORs every group into the sum of the cell that finally owns it, so a cell that keeps both of its groups and takes one from each side sums sixteen terms.

The cells form `NUM_RINGS` separate rings of `RING_CELLS` cells each. Six cells per ring gives the small arrangement and twelve the large one. Each ring closes on itself, so its first and last cells are neighbours. Groups never pass from one ring to another. The network has no state: sums and error flags follow the terms and the configuration within the same cycle. Configurations that make no sense are flagged per cell, and the block resolves each of them in a fixed, documented way.

Top module: `pt_ring_alloc`

## Requirements
- R1: With every configuration field at 00 (keep), each cell's sum is the OR of its own eight terms and no other cell's terms affect it.
- R2: A destination field of 01 sends that group to the previous cell of the same ring (position c-1). The group then adds to that cell's sum and no longer adds to its owner's sum, and the owner's error flag stays low.
- R3: A destination field of 10 sends that group to the next cell of the same ring (position c+1). The group then adds to that cell's sum and no longer adds to its owner's sum.
- R4: The ring wraps around. The previous cell of position 0 is position RING_CELLS-1, and the next cell of position RING_CELLS-1 is position 0.
- R5: A group never reaches a cell of another ring, including at the wrap point.
- R6: A destination field of 11 claims the group for both neighbours. This raises the owner's error flag, and the group is kept by its owner.
- R7: If group A and group B of one cell both name the same neighbour (both 01 or both 10), the owner's error flag rises. Group A is delivered and group B is kept by its owner, so no neighbour receives more than four terms from one side.
- R8: A cell that keeps both groups and receives a group from each neighbour sums sixteen terms, and any single one of those terms drives its sum high.
- R9: Sums and error flags are combinational. A change on the terms or on the configuration shows on the outputs without any clock edge.
- R10: Layout. The cell at position c of ring r has global index k = r*RING_CELLS + c. Its terms are `terms_i[k*8 +: 8]`, with group A in the low four bits and group B in the high four. Its configuration is `cfg_i[k*4 +: 4]`, with bits [1:0] giving A's destination and bits [3:2] giving B's. Its outputs are `sum_o[k]` and `cfg_err_o[k]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| terms_i | input | NUM_RINGS*RING_CELLS*8 | Product terms, eight per cell, group A in the low nibble |
| cfg_i | input | NUM_RINGS*RING_CELLS*4 | Per-cell destinations: [1:0] group A, [3:2] group B |
| sum_o | output | NUM_RINGS*RING_CELLS | OR sum per cell after allocation |
| cfg_err_o | output | NUM_RINGS*RING_CELLS | Per-cell flag for a dual claim or a doubled feed |

## Verification
The bench targets the two wrap points of each ring. A design with a wrong modulo would send a group from position 0 to the wrong cell, or across into the other ring's cells, and the bench would see that sum set in the wrong place. It lends groups in both directions and looks at the owner as well as the receiver, so a design that kept a lent group in its owner's sum is caught. The two illegal forms are driven with live terms, which exposes a design that dropped the contested group or delivered it twice. The full sixteen-term case walks a single active term through every input, which finds any borrowed path that is not wired.

// File: rtl/ring_alloc_pkg.sv
package ring_alloc_pkg;

  // Per-group destination code
  typedef enum logic [1:0] {
    DST_KEEP = 2'b00,
    DST_PREV = 2'b01,
    DST_NEXT = 2'b10,
    DST_BAD  = 2'b11
  } dest_e;

  localparam int GROUPS_PER_CELL = 2;
  localparam int CFG_BITS        = 2 * GROUPS_PER_CELL;

endpackage

// File: rtl/pta_cell_router.sv
module pta_cell_router
  import ring_alloc_pkg::*;
#(
  parameter int GROUP_TERMS = 4,
  localparam int CELL_TERMS = GROUPS_PER_CELL * GROUP_TERMS
) (
  input  logic [CELL_TERMS-1:0] terms_i,
  input  logic [CFG_BITS-1:0]   cfg_i,
  output logic                  keep_o,
  output logic                  to_prev_o,
  output logic                  to_next_o,
  output logic                  err_o
);

  logic  grp_a_or, grp_b_or;
  dest_e dst_a, dst_b;
  dest_e eff_a, eff_b;

  assign grp_a_or = |terms_i[GROUP_TERMS-1:0];
  assign grp_b_or = |terms_i[CELL_TERMS-1:GROUP_TERMS];

  always_comb begin
    dst_a = dest_e'(cfg_i[1:0]);
    dst_b = dest_e'(cfg_i[3:2]);
    // a dual claim leaves the group with its owner
    eff_a = (dst_a == DST_BAD) ? DST_KEEP : dst_a;
    eff_b = (dst_b == DST_BAD) ? DST_KEEP : dst_b;
    // one group per side at most: B yields to A
    if (eff_b != DST_KEEP && eff_b == eff_a) begin
      eff_b = DST_KEEP;
    end
  end

  always_comb begin
    err_o = (dst_a == DST_BAD) || (dst_b == DST_BAD) ||
            ((dst_a == dst_b) && (dst_a == DST_PREV || dst_a == DST_NEXT));
    keep_o    = (eff_a == DST_KEEP && grp_a_or) || (eff_b == DST_KEEP && grp_b_or);
    to_prev_o = (eff_a == DST_PREV && grp_a_or) || (eff_b == DST_PREV && grp_b_or);
    to_next_o = (eff_a == DST_NEXT && grp_a_or) || (eff_b == DST_NEXT && grp_b_or);
  end

endmodule

// File: rtl/pta_ring.sv
module pta_ring
  import ring_alloc_pkg::*;
#(
  parameter int CELLS       = 6,
  parameter int GROUP_TERMS = 4,
  localparam int CELL_TERMS = GROUPS_PER_CELL * GROUP_TERMS
) (
  input  logic [CELLS*CELL_TERMS-1:0] terms_i,
  input  logic [CELLS*CFG_BITS-1:0]   cfg_i,
  output logic [CELLS-1:0]            sum_o,
  output logic [CELLS-1:0]            err_o
);

  logic [CELLS-1:0] keep, to_prev, to_next;

  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    localparam int PRV = (c + CELLS - 1) % CELLS;
    localparam int NXT = (c + 1) % CELLS;

    pta_cell_router #(.GROUP_TERMS(GROUP_TERMS)) u_router (
      .terms_i   (terms_i[c*CELL_TERMS +: CELL_TERMS]),
      .cfg_i     (cfg_i[c*CFG_BITS +: CFG_BITS]),
      .keep_o    (keep[c]),
      .to_prev_o (to_prev[c]),
      .to_next_o (to_next[c]),
      .err_o     (err_o[c])
    );

    // own kept groups, plus what each neighbour sends this way
    assign sum_o[c] = keep[c] | to_next[PRV] | to_prev[NXT];
  end

endmodule

// File: rtl/pt_ring_alloc.sv
module pt_ring_alloc
  import ring_alloc_pkg::*;
#(
  parameter int RING_CELLS  = 6,
  parameter int NUM_RINGS   = 2,
  parameter int GROUP_TERMS = 4,
  localparam int CELLS      = RING_CELLS * NUM_RINGS,
  localparam int CELL_TERMS = GROUPS_PER_CELL * GROUP_TERMS
) (
  input  logic [CELLS*CELL_TERMS-1:0] terms_i,
  input  logic [CELLS*CFG_BITS-1:0]   cfg_i,
  output logic [CELLS-1:0]            sum_o,
  output logic [CELLS-1:0]            cfg_err_o
);

  for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
    localparam int T_W = RING_CELLS * CELL_TERMS;
    localparam int C_W = RING_CELLS * CFG_BITS;

    pta_ring #(.CELLS(RING_CELLS), .GROUP_TERMS(GROUP_TERMS)) u_ring (
      .terms_i (terms_i[r*T_W +: T_W]),
      .cfg_i   (cfg_i[r*C_W +: C_W]),
      .sum_o   (sum_o[r*RING_CELLS +: RING_CELLS]),
      .err_o   (cfg_err_o[r*RING_CELLS +: RING_CELLS])
    );
  end

endmodule

// File: rtl/pt_ring_alloc_chk.sv
module pt_ring_alloc_chk #(
  parameter int RING_CELLS  = 6,
  parameter int NUM_RINGS   = 2,
  parameter int GROUP_TERMS = 4,
  localparam int CELLS      = RING_CELLS * NUM_RINGS,
  localparam int CELL_TERMS = 2 * GROUP_TERMS
) (
  input logic [CELLS*CELL_TERMS-1:0] terms_i,
  input logic [CELLS*4-1:0]          cfg_i,
  input logic [CELLS-1:0]            sum_o,
  input logic [CELLS-1:0]            cfg_err_o
);

  always_comb begin
    for (int k = 0; k < CELLS; k++) begin
      automatic int r = k / RING_CELLS;
      automatic int c = k % RING_CELLS;
      automatic int p = r*RING_CELLS + (c + RING_CELLS - 1) % RING_CELLS;
      automatic int n = r*RING_CELLS + (c + 1) % RING_CELLS;
      automatic logic [1:0] a  = cfg_i[k*4 +: 2];
      automatic logic [1:0] b  = cfg_i[k*4+2 +: 2];
      automatic logic [3:0] pc = cfg_i[p*4 +: 4];
      automatic logic [3:0] nc = cfg_i[n*4 +: 4];
      automatic logic quiet_nb = (pc[1:0] != 2'b10) && (pc[3:2] != 2'b10) &&
                                 (nc[1:0] != 2'b01) && (nc[3:2] != 2'b01);
      if (a == 2'b11 || b == 2'b11)
        AST_ERR_DUAL: assert (cfg_err_o[k]); // R6
      if (a == b && (a == 2'b01 || a == 2'b10))
        AST_ERR_SAME_SIDE: assert (cfg_err_o[k]); // R7
      if (a != 2'b11 && b != 2'b11 && !(a == b && a != 2'b00))
        AST_NO_FALSE_ERR: assert (!cfg_err_o[k]); // R2
      if (a == 2'b00 && b == 2'b00 && quiet_nb)
        AST_ISOLATED_SUM: assert (sum_o[k] == |terms_i[k*CELL_TERMS +: CELL_TERMS]); // R1
      if (a == 2'b01 && b == 2'b10 && quiet_nb)
        AST_ALL_LENT: assert (!sum_o[k]); // R3
    end
  end

endmodule

bind pt_ring_alloc pt_ring_alloc_chk #(
  .RING_CELLS (RING_CELLS),
  .NUM_RINGS  (NUM_RINGS),
  .GROUP_TERMS(GROUP_TERMS)
) u_chk (
  .terms_i   (terms_i),
  .cfg_i     (cfg_i),
  .sum_o     (sum_o),
  .cfg_err_o (cfg_err_o)
);

// File: tb/pt_ring_alloc_test.sv
`timescale 1ns/1ps
module pt_ring_alloc_test;

  localparam int RC = 6;
  localparam int NR = 2;
  localparam int NC = RC * NR;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC*8-1:0] terms = '0;
  logic [NC*4-1:0] cfg = '0;
  logic [NC-1:0]   sum;
  logic [NC-1:0]   err;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pt_ring_alloc #(.RING_CELLS(RC), .NUM_RINGS(NR), .GROUP_TERMS(4)) uut (
    .terms_i(terms), .cfg_i(cfg), .sum_o(sum), .cfg_err_o(err)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  function automatic int gi(int r, int c);
    return r*RC + c;
  endfunction

  function automatic logic [NC-1:0] bit_at(int k);
    logic [NC-1:0] v = '0;
    v[k] = 1'b1;
    return v;
  endfunction

  task automatic clear_all();
    terms = '0;
    cfg = '0;
  endtask

  task automatic set_cfg(int k, logic [1:0] a, logic [1:0] b);
    cfg[k*4 +: 4] = {b, a};
  endtask

  task automatic settle();
    @(negedge clk);
    #2;
  endtask

  task automatic check(string req, logic [NC-1:0] act, logic [NC-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic t_reset_state();
    clear_all();
    settle();
    check("R1 idle sums", sum, '0);
    check("R1 idle errors", err, '0);
  endtask

  task automatic t_keep_all();
    for (int k = 0; k < NC; k++) begin
      clear_all();
      terms[k*8 + 6] = 1'b1;
      settle();
      check("R1 R10 own term", sum, bit_at(k));
    end
  endtask

  task automatic t_lend_prev();
    clear_all();
    set_cfg(gi(0,2), 2'b01, 2'b00);
    terms[gi(0,2)*8 + 1] = 1'b1;
    settle();
    check("R2 group A to previous", sum, bit_at(gi(0,1)));
    check("R2 no error", err, '0);
  endtask

  task automatic t_lend_next();
    clear_all();
    set_cfg(gi(0,2), 2'b00, 2'b10);
    terms[gi(0,2)*8 + 5] = 1'b1;
    settle();
    check("R3 group B to next", sum, bit_at(gi(0,3)));
  endtask

  task automatic t_wrap();
    clear_all();
    set_cfg(gi(0,0), 2'b01, 2'b00);
    terms[gi(0,0)*8 + 0] = 1'b1;
    settle();
    check("R4 position 0 to last", sum, bit_at(gi(0,RC-1)));
    clear_all();
    set_cfg(gi(0,RC-1), 2'b00, 2'b10);
    terms[gi(0,RC-1)*8 + 7] = 1'b1;
    settle();
    check("R4 last to position 0", sum, bit_at(gi(0,0)));
  endtask

  task automatic t_ring_isolation();
    clear_all();
    set_cfg(gi(1,0), 2'b01, 2'b00);
    terms[gi(1,0)*8 + 2] = 1'b1;
    settle();
    check("R5 ring 1 wraps inside ring 1", sum, bit_at(gi(1,RC-1)));
    clear_all();
    set_cfg(gi(0,RC-1), 2'b00, 2'b10);
    terms[gi(0,RC-1)*8 + 4] = 1'b1;
    settle();
    check("R5 ring 0 end stays in ring 0", sum, bit_at(gi(0,0)));
  endtask

  task automatic t_dual_claim();
    clear_all();
    set_cfg(gi(1,3), 2'b11, 2'b00);
    terms[gi(1,3)*8 + 3] = 1'b1;
    settle();
    check("R6 dual claim kept", sum, bit_at(gi(1,3)));
    check("R6 dual claim flagged", err, bit_at(gi(1,3)));
  endtask

  task automatic t_same_side();
    clear_all();
    set_cfg(gi(0,4), 2'b01, 2'b01);
    terms[gi(0,4)*8 + 6] = 1'b1;
    settle();
    check("R7 group B kept", sum, bit_at(gi(0,4)));
    check("R7 flagged", err, bit_at(gi(0,4)));
    clear_all();
    set_cfg(gi(0,4), 2'b01, 2'b01);
    terms[gi(0,4)*8 + 2] = 1'b1;
    settle();
    check("R7 group A delivered", sum, bit_at(gi(0,3)));
  endtask

  task automatic t_sixteen();
    int tgt;
    int p;
    int nx;
    tgt = gi(1,3);
    p = gi(1,2);
    nx = gi(1,4);
    for (int t = 0; t < 16; t++) begin
      clear_all();
      set_cfg(p, 2'b00, 2'b10);
      set_cfg(nx, 2'b01, 2'b00);
      if (t < 8)       terms[tgt*8 + t] = 1'b1;
      else if (t < 12) terms[p*8 + 4 + (t-8)] = 1'b1;
      else             terms[nx*8 + (t-12)] = 1'b1;
      settle();
      check("R8 sixteen-term sum", sum, bit_at(tgt));
    end
  endtask

  task automatic t_comb();
    clear_all();
    settle();
    terms[gi(0,1)*8] = 1'b1;
    #1;
    check("R9 same-cycle term change", sum, bit_at(gi(0,1)));
    set_cfg(gi(0,1), 2'b10, 2'b00);
    #1;
    check("R9 same-cycle config change", sum, bit_at(gi(0,2)));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_keep_all();
    t_lend_prev();
    t_lend_next();
    t_wrap();
    t_ring_isolation();
    t_dual_claim();
    t_same_side();
    t_sixteen();
    t_comb();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule